// File: doc/BRIEF.md
# Strap-Addressed Serial Register Slave

This block is a two-wire serial (I2C) slave that gives an external host access to a small bank of 8-bit control registers. The system clock oversamples SCL and SDA, which must be several times faster than the bus, and the block serves fast-mode traffic at up to 400 kbit/s. It does not stretch the clock. One strap input chooses between two fixed 7-bit device addresses, so two instances can share a bus.

In a write transfer, the first byte after the device address sets the internal sub-address pointer. Each later byte is stored at the pointer, and the pointer then advances. A read transfer returns bytes from the current pointer, which advances after each byte the host acknowledges. Register 0 is a read-only window onto a status input. Register 3 keeps only its low nibble. The top two registers, and every pointer value beyond the bank, are reserved: they ignore writes and read as zero. The stored configuration is available as a flat vector, and each accepted data byte also appears on a one-cycle write strobe bus.

Top module: `i2c_reg_slave`

## Requirements
- R1: The slave acknowledges address byte `{7'b1000100, rw}` when `addr_sel_i`=0 and `{7'b1000101, rw}` when `addr_sel_i`=1. For any other address it never pulls SDA low.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A STOP in the middle of a byte abandons that byte with no write. The slave changes its SDA drive only while SCL is low.
- R3: In a write transfer, the first byte after the address loads the pointer and causes no register write.
- R4: Each later write byte pulses `reg_we_o` for one cycle, with `reg_addr_o` set to the pointer and `reg_wdata_o` set to the byte. The pointer then increments modulo 256. The configuration changes only on such a pulse.
- R5: Writes to registers 6 and 7, and to pointer values 8 to 255, have no effect. These locations read as 0x00.
- R6: Bits 7:4 of register 3 ignore writes and read as 0. Bits 3:0 store the written value.
- R7: Register 0 reads as `status_i`, and host writes to it have no effect.
- R8: A read transfer returns bytes MSB first, starting at the pointer. The pointer increments after each byte the master acknowledges and does not increment after a non-acknowledged byte.
- R9: After the master does not acknowledge a read byte, the slave leaves SDA released until the next START.
- R10: A repeated START restarts address decoding and leaves the pointer unchanged.
- R11: The slave acknowledges every byte of a write transfer addressed to it, including the pointer byte.
- R12: After reset, SDA is released and all stored registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as sampled |
| sda_i | input | 1 | Bus data line as sampled (wired level) |
| addr_sel_i | input | 1 | Strap that selects the device address |
| status_i | input | 8 | Hardware value returned by register 0 |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| reg_we_o | output | 1 | One-cycle strobe for each accepted data byte |
| reg_addr_o | output | 8 | Pointer value for the strobed byte |
| reg_wdata_o | output | 8 | Data byte for the strobed write |
| cfg_o | output | NUM_REGS*8 | Stored register contents, register i at bits [8i+7:8i] |

## Verification
A corrupted bit counter or shift register shows on the bus within one byte: either the acknowledge slot appears at the wrong SCL pulse, or the read-back data is shifted, and a byte-by-byte read-back detects both. A pointer that slips or fails to advance shows on the next byte as a mismatch against a bench model that applies the masking rules arithmetically. A state machine that ignores START or STOP leaves the slave driving SDA, or failing to acknowledge, in the very next transfer. Masking faults appear on `cfg_o` one cycle after the write strobe.

// File: rtl/i2c_regs_pkg.sv
package i2c_regs_pkg;
  localparam logic [6:0] DEV_ADDR_BASE = 7'b1000100;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK
  } slv_state_e;

  // writable bit mask per register index; 0 means reserved or read-only
  function automatic logic [7:0] wr_mask(int idx, int num_regs);
    if (idx == 0) return 8'h00;
    if (idx >= num_regs - 2) return 8'h00;
    if (idx == 3) return 8'h0F;
    return 8'hFF;
  endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] raw_i,
  output logic [LINES-1:0] sync_o,
  output logic [LINES-1:0] rise_o,
  output logic [LINES-1:0] fall_o
);
  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic [STAGES:0] pipe_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= '1;
      else         pipe_q <= {pipe_q[STAGES-1:0], raw_i[l]};
    end
    assign sync_o[l] = pipe_q[STAGES-1];
    assign rise_o[l] = pipe_q[STAGES-1] & ~pipe_q[STAGES];
    assign fall_o[l] = ~pipe_q[STAGES-1] & pipe_q[STAGES];
  end
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank
  import i2c_regs_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [7:0]            waddr_i,
  input  logic [7:0]            wdata_i,
  input  logic [7:0]            raddr_i,
  input  logic [7:0]            status_i,
  output logic [7:0]            rdata_o,
  output logic [NUM_REGS*8-1:0] cfg_o
);
  localparam int IDX_W = $clog2(NUM_REGS);

  logic [7:0] regs [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [7:0] MASK = wr_mask(g, NUM_REGS);
    if (MASK != 8'h00) begin : g_rw
      logic [7:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                          q <= '0;
        else if (we_i && waddr_i == 8'(g))    q <= wdata_i & MASK;
      end
      assign regs[g] = q;
    end else begin : g_fixed
      assign regs[g] = '0;
    end
    assign cfg_o[g*8 +: 8] = regs[g];
  end

  always_comb begin
    rdata_o = '0;
    if (raddr_i < 8'(NUM_REGS)) begin
      if (raddr_i == 8'd0) rdata_o = status_i;
      else                 rdata_o = regs[raddr_i[IDX_W-1:0]];
    end
  end
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import i2c_regs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       sda_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       addr_sel_i,
  input  logic [7:0] rdata_i,
  output logic       sda_oe_o,
  output logic       we_o,
  output logic [7:0] waddr_o,
  output logic [7:0] wdata_o,
  output logic [7:0] ptr_o
);
  slv_state_e state_q;
  logic [7:0] sh_q;
  logic [2:0] cnt_q;
  logic       byte_done_q, first_q, rnw_q, mack_q;
  logic [6:0] dev_addr;

  assign dev_addr = DEV_ADDR_BASE | {6'd0, addr_sel_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      sh_q        <= '0;
      cnt_q       <= '0;
      byte_done_q <= 1'b0;
      first_q     <= 1'b0;
      rnw_q       <= 1'b0;
      mack_q      <= 1'b0;
      sda_oe_o    <= 1'b0;
      we_o        <= 1'b0;
      waddr_o     <= '0;
      wdata_o     <= '0;
      ptr_o       <= '0;
    end else begin
      we_o <= 1'b0;
      if (start_i) begin
        state_q     <= ST_ADDR;
        cnt_q       <= '0;
        byte_done_q <= 1'b0;
        first_q     <= 1'b1;
        sda_oe_o    <= 1'b0;
      end else if (stop_i) begin
        state_q  <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_WR: begin
            if (scl_rise_i && !byte_done_q) begin
              sh_q <= {sh_q[6:0], sda_i};
              if (cnt_q == 3'd7) byte_done_q <= 1'b1;
              else               cnt_q <= cnt_q + 3'd1;
            end
            if (scl_fall_i && byte_done_q) begin
              byte_done_q <= 1'b0;
              cnt_q       <= '0;
              if (state_q == ST_ADDR) begin
                if (sh_q[7:1] == dev_addr) begin
                  sda_oe_o <= 1'b1;
                  rnw_q    <= sh_q[0];
                  state_q  <= ST_ADDR_ACK;
                end else begin
                  state_q <= ST_IDLE;
                end
              end else begin
                sda_oe_o <= 1'b1;
                state_q  <= ST_WR_ACK;
                if (first_q) begin
                  ptr_o   <= sh_q;
                  first_q <= 1'b0;
                end else begin
                  we_o    <= 1'b1;
                  waddr_o <= ptr_o;
                  wdata_o <= sh_q;
                  ptr_o   <= ptr_o + 8'd1;
                end
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall_i) begin
              if (rnw_q) begin
                sh_q     <= rdata_i;
                sda_oe_o <= ~rdata_i[7];
                cnt_q    <= '0;
                state_q  <= ST_RD;
              end else begin
                sda_oe_o <= 1'b0;
                state_q  <= ST_WR;
              end
            end
          end
          ST_WR_ACK: begin
            if (scl_fall_i) begin
              sda_oe_o <= 1'b0;
              state_q  <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_fall_i) begin
              if (cnt_q == 3'd7) begin
                sda_oe_o <= 1'b0;
                state_q  <= ST_RD_ACK;
              end else begin
                cnt_q    <= cnt_q + 3'd1;
                sh_q     <= {sh_q[6:0], 1'b0};
                sda_oe_o <= ~sh_q[6];
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise_i) begin
              mack_q <= ~sda_i;
              if (!sda_i) ptr_o <= ptr_o + 8'd1;
            end
            if (scl_fall_i) begin
              if (mack_q) begin
                sh_q     <= rdata_i;
                sda_oe_o <= ~rdata_i[7];
                cnt_q    <= '0;
                state_q  <= ST_RD;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave #(
  parameter int NUM_REGS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  scl_i,
  input  logic                  sda_i,
  input  logic                  addr_sel_i,
  input  logic [7:0]            status_i,
  output logic                  sda_oe_o,
  output logic                  reg_we_o,
  output logic [7:0]            reg_addr_o,
  output logic [7:0]            reg_wdata_o,
  output logic [NUM_REGS*8-1:0] cfg_o
);
  logic [1:0] line_s, line_rise, line_fall;
  logic       scl_s, start_det, stop_det;
  logic [7:0] ptr, rdata;

  i2c_line_sync #(.LINES(2), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  ({sda_i, scl_i}),
    .sync_o (line_s),
    .rise_o (line_rise),
    .fall_o (line_fall)
  );

  assign scl_s     = line_s[0];
  assign start_det = line_fall[1] & scl_s;
  assign stop_det  = line_rise[1] & scl_s;

  i2c_slave_fsm i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_rise_i (line_rise[0]),
    .scl_fall_i (line_fall[0]),
    .sda_i      (line_s[1]),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .addr_sel_i (addr_sel_i),
    .rdata_i    (rdata),
    .sda_oe_o   (sda_oe_o),
    .we_o       (reg_we_o),
    .waddr_o    (reg_addr_o),
    .wdata_o    (reg_wdata_o),
    .ptr_o      (ptr)
  );

  i2c_reg_bank #(.NUM_REGS(NUM_REGS)) i_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_o),
    .waddr_i  (reg_addr_o),
    .wdata_i  (reg_wdata_o),
    .raddr_i  (ptr),
    .status_i (status_i),
    .rdata_o  (rdata),
    .cfg_o    (cfg_o)
  );
endmodule

// File: rtl/i2c_reg_slave_chk.sv
module i2c_reg_slave_chk #(
  parameter int NUM_REGS = 8
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  scl_s,
  input logic                  sda_oe_o,
  input logic                  reg_we_o,
  input logic [7:0]            reg_addr_o,
  input logic [7:0]            reg_wdata_o,
  input logic [NUM_REGS*8-1:0] cfg_o
);
  assert_drive_scl_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_s);

  assert_strobe_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);

  assert_cfg_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_we_o |=> $stable(cfg_o));

  assert_reserved_reg_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_o && reg_addr_o >= 8'(NUM_REGS - 2)) |=> $stable(cfg_o));

  assert_reserved_bits_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_o && reg_addr_o == 8'd3) |=>
      (cfg_o[31:28] == 4'd0 && cfg_o[27:24] == $past(reg_wdata_o[3:0])));

  assert_ro_reg0_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_o && reg_addr_o == 8'd0) |=> $stable(cfg_o));
endmodule

bind i2c_reg_slave i2c_reg_slave_chk #(.NUM_REGS(NUM_REGS)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .scl_s       (scl_s),
  .sda_oe_o    (sda_oe_o),
  .reg_we_o    (reg_we_o),
  .reg_addr_o  (reg_addr_o),
  .reg_wdata_o (reg_wdata_o),
  .cfg_o       (cfg_o)
);

// File: tb/test_i2c_reg_slave.sv
module test_i2c_reg_slave;
  localparam int N = 8;
  localparam int Q = 30;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         scl = 1'b1;
  logic         sda_m = 1'b1;
  logic         addr_sel = 1'b0;
  logic [7:0]   status = 8'hC3;
  logic         sda_oe, we;
  logic [7:0]   waddr, wdata;
  logic [N*8-1:0] cfg;
  logic         sda_line;

  int checks = 0;
  int errors = 0;
  int we_cnt = 0;
  logic [7:0] last_a = '0, last_d = '0;
  logic [7:0] mdl [N];
  bit done = 0;

  always #4 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_reg_slave #(.NUM_REGS(N)) i_i2c_reg_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .addr_sel_i(addr_sel), .status_i(status), .sda_oe_o(sda_oe),
    .reg_we_o(we), .reg_addr_o(waddr), .reg_wdata_o(wdata), .cfg_o(cfg)
  );

  always @(negedge clk) if (we) begin
    we_cnt <= we_cnt + 1;
    last_a <= waddr;
    last_d <= wdata;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] store_val(int i, logic [7:0] v);
    if (i == 0 || i >= N - 2) return 8'h00;
    if (i == 3) return v & 8'h0F;
    return v;
  endfunction

  function automatic logic [7:0] read_val(int p);
    if (p >= N) return 8'h00;
    if (p == 0) return status;
    return mdl[p];
  endfunction

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); b = sda_line; wq(); scl = 1'b0; wq();
  endtask

  task automatic write_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(b);
    ack = ~b;
  endtask

  task automatic read_byte(input logic mack, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) recv_bit(v[i]);
    send_bit(~mack);
  endtask

  task automatic set_ptr(input logic [7:0] p);
    logic a;
    bus_start();
    write_byte(8'h88, a);
    check(a, "R1", a, 1);
    write_byte(p, a);
    check(a, "R11", a, 1);
  endtask

  initial begin
    logic ack;
    logic [7:0] v;
    int n0;
    for (int i = 0; i < N; i++) mdl[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R12 reset state
    check(sda_oe == 1'b0, "R12", sda_oe, 0);
    check(cfg == '0, "R12", cfg[31:0], 0);

    // R1 address sweep across both strap values
    for (int s = 0; s < 2; s++) begin
      addr_sel = s[0];
      for (int a = 8'h40; a < 8'h50; a++) begin
        n0 = we_cnt;
        bus_start();
        write_byte({a[6:0], 1'b0}, ack);
        bus_stop();
        check(ack == (a == (8'h44 | s)), "R1", ack, (a == (8'h44 | s)));
        check(we_cnt == n0, "R1", we_cnt, n0);
      end
    end
    addr_sel = 1'b0;

    // R3/R4/R11 burst write of all registers from pointer 0
    n0 = we_cnt;
    set_ptr(8'h00);
    check(we_cnt == n0, "R3", we_cnt, n0);
    for (int i = 0; i < N; i++) begin
      v = 8'h5A + 8'(i * 8'h31);
      write_byte(v, ack);
      check(ack, "R11", ack, 1);
      mdl[i] = store_val(i, v);
    end
    bus_stop();
    check(we_cnt == n0 + N, "R4", we_cnt, n0 + N);
    check(last_a == 8'(N - 1), "R4", last_a, N - 1);
    check(last_d == 8'h5A + 8'((N - 1) * 8'h31), "R4", last_d, 8'h5A + 8'((N - 1) * 8'h31));
    for (int i = 0; i < N; i++)
      check(cfg[i*8 +: 8] == mdl[i], i == 3 ? "R6" : (i == 0 ? "R7" : "R5"), cfg[i*8 +: 8], mdl[i]);

    // R8/R10 burst read after repeated start
    set_ptr(8'h00);
    bus_start();
    write_byte(8'h89, ack);
    check(ack, "R10", ack, 1);
    for (int i = 0; i < N; i++) begin
      read_byte(i != N - 1, v);
      check(v == read_val(i), "R8", v, read_val(i));
    end
    bus_stop();

    // R10 pointer kept over repeated start; R8 no increment on nack
    set_ptr(8'h02);
    bus_start(); write_byte(8'h89, ack);
    read_byte(1'b0, v);
    check(v == read_val(2), "R10", v, read_val(2));
    bus_start(); write_byte(8'h89, ack);
    read_byte(1'b0, v);
    check(v == read_val(2), "R8", v, read_val(2));
    bus_start(); write_byte(8'h89, ack);
    read_byte(1'b1, v);
    read_byte(1'b0, v);
    check(v == read_val(3), "R8", v, read_val(3));
    bus_stop();
    bus_start(); write_byte(8'h89, ack);
    read_byte(1'b0, v);
    check(v == read_val(3), "R8", v, read_val(3));
    // R9 released after nack: extra clocks read all ones
    read_byte(1'b0, v);
    check(v == 8'hFF, "R9", v, 8'hFF);
    check(sda_oe == 1'b0, "R9", sda_oe, 0);
    bus_stop();

    // R5/R7 writes beyond bank wrap onto read-only register 0
    n0 = we_cnt;
    set_ptr(8'hFE);
    write_byte(8'h11, ack); write_byte(8'h22, ack); write_byte(8'h33, ack);
    check(ack, "R11", ack, 1);
    bus_stop();
    check(we_cnt == n0 + 3, "R4", we_cnt, n0 + 3);
    check(last_a == 8'h00, "R4", last_a, 0);
    for (int i = 0; i < N; i++)
      check(cfg[i*8 +: 8] == mdl[i], "R5", cfg[i*8 +: 8], mdl[i]);
    status = 8'h3C;
    set_ptr(8'hFE);
    bus_start(); write_byte(8'h89, ack);
    read_byte(1'b1, v); check(v == 8'h00, "R5", v, 0);
    read_byte(1'b1, v); check(v == 8'h00, "R5", v, 0);
    read_byte(1'b0, v); check(v == 8'h3C, "R7", v, 8'h3C);
    bus_stop();

    // R2 stop inside a data byte abandons it
    n0 = we_cnt;
    set_ptr(8'h01);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    bus_stop();
    check(we_cnt == n0, "R2", we_cnt, n0);
    check(cfg[15:8] == mdl[1], "R2", cfg[15:8], mdl[1]);
    bus_start(); write_byte(8'h89, ack);
    check(ack, "R2", ack, 1);
    read_byte(1'b0, v);
    check(v == mdl[1], "R2", v, mdl[1]);
    bus_stop();
    check(sda_oe == 1'b0, "R2", sda_oe, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule